// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a flash cycle engine and decides, for every flash access, whether it may proceed. It holds a small bank of protection windows. Each window covers a run of 4 KB pages. It has two separate enables: one guards reads, the other guards writes and erases. An access whose page falls inside an enabled window of the matching kind is refused. The cycle engine turns a refusal into a flash cycle error.

Software loads the windows through a simple register-write port and can read them back through a read port. Once the lock input is pulsed, the windows are frozen and cannot change until the next reset. Each request is answered one clock later with either a grant or a violation.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every window register reads 0, `lockState` is 0, and `rspValid`, `rspGrant` and `rspViolation` are all 0.
- R2: A window register is 32 bits and is written when `cfgWrEn` is high at a clock edge with `cfgIdx` in 0..4. Its fields are:
  - bits 12:0: lower page;
  - bit 15: read-guard enable;
  - bits 28:16: upper page;
  - bit 31: write/erase-guard enable.
  Bits 30:29 and 14:13 are not stored and read back as 0. `cfgRdData` shows the register selected by `cfgRdIdx`. A write with `cfgIdx` 5..7 changes nothing, and reading such an index returns 0.
- R3: A write/erase request (`reqIsWrite`=1) gets a violation if some window with bit 31 set satisfies lower ≤ `reqAddr[24:12]` ≤ upper. Otherwise it gets a grant.
- R4: A read request (`reqIsWrite`=0) gets a violation if some window with bit 15 set satisfies lower ≤ `reqAddr[24:12]` ≤ upper. Otherwise it gets a grant.
- R5: Both bounds are inclusive at byte level. The lower page starts at offset 0x000 and the upper page ends at offset 0xFFF. The byte just below the lower page and the byte just above the upper page are not covered. A window whose upper page is below its lower page covers nothing.
- R6: The two enables act independently. A window with only the read enable never blocks writes, and a window with only the write enable never blocks reads.
- R7: When `reqValid` is high at an edge, `rspValid` is high after that edge with exactly one of `rspGrant`/`rspViolation` high. When `reqValid` is low, all three outputs are low after that edge.
- R8: `lockSet` high at an edge sets `lockState`, which stays set until reset. A register write made while `lockState` is set, or in the same cycle as `lockSet`, is ignored. After a reset, writes are accepted again.
- R9: A request sampled at the same edge as a register write is judged against the old register contents. Requests at later edges see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Window register write strobe |
| cfgIdx | input | 3 | Window register index for writes |
| cfgWrData | input | 32 | Window register write data |
| cfgRdIdx | input | 3 | Window register index for read-back |
| cfgRdData | output | 32 | Read-back of the selected window register |
| lockSet | input | 1 | Sets the sticky lock |
| lockState | output | 1 | Lock is active |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 25 | Flash byte address of the access |
| reqIsWrite | input | 1 | 1 for write/erase, 0 for read |
| rspValid | output | 1 | Answer for the request of the previous cycle |
| rspGrant | output | 1 | Access allowed |
| rspViolation | output | 1 | Access refused |

## Verification
Requests are driven with random windows, random enable pairs and random addresses. The windows are clustered over a few dozen pages, so hits, misses and overlaps all occur, and the answers are compared with a bench model of the window test. Directed cases then place addresses on the first and last byte of a window and one byte outside it, which separates an inclusive compare from an exclusive one and a page compare from a byte compare. Single-enable windows show that read and write guarding are not swapped or merged. Write-versus-lock and write-versus-request collisions in the same cycle show which edge each update takes effect on.

// File: rtl/frg_pkg.sv
`timescale 1ns/1ps
package frg_pkg;
  localparam int REG_W  = 32;
  localparam int LO_LSB = 0;
  localparam int RD_BIT = 15;
  localparam int UP_LSB = 16;
  localparam int WR_BIT = 31;

  typedef struct packed {
    logic load;    // commit cfgWrData into the indexed window
    logic locked;  // window bank is frozen
  } frgStrobe_t;
endpackage

// File: rtl/frg_datapath.sv
`timescale 1ns/1ps
module frg_datapath
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 25,
  parameter int PAGE_BITS  = 12,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  frgStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [REG_W-1:0]  rdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsWrite,
  output logic              hitAny
);
  localparam int LIMIT_W = ADDR_W - PAGE_BITS;
  localparam logic [REG_W-1:0] LIMIT_ONES = REG_W'((64'd1 << LIMIT_W) - 64'd1);
  localparam logic [REG_W-1:0] KEEP_MASK  = (LIMIT_ONES << LO_LSB) | (LIMIT_ONES << UP_LSB)
                                          | (REG_W'(1) << RD_BIT) | (REG_W'(1) << WR_BIT);

  logic [REG_W-1:0]   rangeQ [NUM_RANGES];
  logic [NUM_RANGES-1:0] hitRd;
  logic [NUM_RANGES-1:0] hitWr;
  logic [LIMIT_W-1:0] reqPage;

  assign reqPage = reqAddr[ADDR_W-1:PAGE_BITS];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : gRange
    logic [LIMIT_W-1:0] loPage;
    logic [LIMIT_W-1:0] upPage;
    logic               inWin;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rangeQ[g] <= '0;
      end else if (strobe.load && wrIdx == IDX_W'(g)) begin
        rangeQ[g] <= wrData & KEEP_MASK;
      end
    end

    assign loPage   = rangeQ[g][LO_LSB +: LIMIT_W];
    assign upPage   = rangeQ[g][UP_LSB +: LIMIT_W];
    assign inWin    = (reqPage >= loPage) && (reqPage <= upPage);
    assign hitRd[g] = rangeQ[g][RD_BIT] & inWin;
    assign hitWr[g] = rangeQ[g][WR_BIT] & inWin;

    // Unstored bits never hold a one.
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      (rangeQ[g] & ~KEEP_MASK) == '0);

    // Once the control reports the lock, the window cannot move.
    assert_frozen_when_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.locked |=> $stable(rangeQ[g]));
  end

  assign hitAny = reqIsWrite ? |hitWr : |hitRd;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (rdIdx == IDX_W'(i)) rdData = rangeQ[i];
    end
  end
endmodule

// File: rtl/frg_control.sv
`timescale 1ns/1ps
module frg_control
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             lockSet,
  input  logic             reqValid,
  input  logic             hitAny,
  output frgStrobe_t       strobe,
  output logic             lockState,
  output logic             rspValid,
  output logic             rspGrant,
  output logic             rspViolation
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RANGES - 1);

  logic lockQ;
  logic validQ, grantQ, violQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else if (lockSet) lockQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      grantQ <= 1'b0;
      violQ  <= 1'b0;
    end else begin
      validQ <= reqValid;
      grantQ <= reqValid & ~hitAny;
      violQ  <= reqValid & hitAny;
    end
  end

  assign strobe.load   = cfgWrEn && !lockQ && !lockSet && (cfgIdx <= LAST_IDX);
  assign strobe.locked = lockQ;
  assign lockState     = lockQ;
  assign rspValid      = validQ;
  assign rspGrant      = grantQ;
  assign rspViolation  = violQ;

  assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspGrant != rspViolation));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspGrant && !rspViolation));
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> lockState);
  assert_lock_rises_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockSet |=> lockState);
endmodule

// File: rtl/flash_range_guard.sv
`timescale 1ns/1ps
module flash_range_guard
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 25,
  parameter int PAGE_BITS  = 12,
  parameter int IDX_W      = $clog2(NUM_RANGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgWrData,
  input  logic [IDX_W-1:0]  cfgRdIdx,
  output logic [31:0]       cfgRdData,
  input  logic              lockSet,
  output logic              lockState,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsWrite,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspViolation
);
  frgStrobe_t strobe;
  logic       hitAny;

  frg_control #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .lockSet(lockSet), .reqValid(reqValid), .hitAny(hitAny),
    .strobe(strobe), .lockState(lockState), .rspValid(rspValid),
    .rspGrant(rspGrant), .rspViolation(rspViolation)
  );

  frg_datapath #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W),
                 .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(cfgIdx),
    .wrData(cfgWrData), .rdIdx(cfgRdIdx), .rdData(cfgRdData),
    .reqAddr(reqAddr), .reqIsWrite(reqIsWrite), .hitAny(hitAny)
  );
endmodule

// File: tb/tb_flash_range_guard.sv
`timescale 1ns/1ps
module tb_flash_range_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [31:0] cfgWrData = '0;
  logic [2:0]  cfgRdIdx = '0;
  logic [31:0] cfgRdData;
  logic        lockSet = 1'b0;
  logic        lockState;
  logic        reqValid = 1'b0;
  logic [24:0] reqAddr = '0;
  logic        reqIsWrite = 1'b0;
  logic        rspValid, rspGrant, rspViolation;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [5];
  logic        lockM;

  always #2 clk = ~clk;

  flash_range_guard dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgWrData(cfgWrData), .cfgRdIdx(cfgRdIdx), .cfgRdData(cfgRdData),
    .lockSet(lockSet), .lockState(lockState), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqIsWrite(reqIsWrite), .rspValid(rspValid),
    .rspGrant(rspGrant), .rspViolation(rspViolation)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expViol(logic [24:0] a, logic wr);
    for (int i = 0; i < 5; i++) begin
      logic en;
      en = wr ? model[i][31] : model[i][15];
      if (en && a[24:12] >= model[i][12:0] && a[24:12] <= model[i][28:16]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] mkReg(logic wr, logic rd, int lo, int up);
    return {wr, 2'b11, 13'(up), rd, 2'b11, 13'(lo)};
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    for (int i = 0; i < 5; i++) model[i] = '0;
    lockM = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Write (optionally with lock and/or a request in the same cycle).
  task automatic cfgWrite(int idx, logic [31:0] d, logic doLock,
                          logic withReq, logic [24:0] a, logic wr, string tag);
    logic exp;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = 3'(idx); cfgWrData = d; lockSet = doLock;
    reqValid = withReq; reqAddr = a; reqIsWrite = wr;
    exp = expViol(a, wr);
    @(posedge clk);
    #1;
    if (!lockM && !doLock && idx < 5) model[idx] = d & 32'h9FFF_9FFF;
    if (doLock) lockM = 1'b1;
    if (withReq) begin
      check({tag, " R9 same-cycle viol"}, {31'd0, rspViolation}, {31'd0, exp});
      check({tag, " R9 same-cycle grant"}, {31'd0, rspGrant}, {31'd0, !exp});
    end
    cfgWrEn = 1'b0; lockSet = 1'b0; reqValid = 1'b0;
  endtask

  task automatic request(logic [24:0] a, logic wr, string tag);
    logic exp;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqIsWrite = wr;
    exp = expViol(a, wr);
    @(posedge clk);
    #1;
    check({tag, " R7 valid"}, {31'd0, rspValid}, 32'd1);
    check({tag, " viol"}, {31'd0, rspViolation}, {31'd0, exp});
    check({tag, " grant"}, {31'd0, rspGrant}, {31'd0, !exp});
    reqValid = 1'b0;
  endtask

  task automatic expectReq(logic [24:0] a, logic wr, logic exp, string tag);
    check({tag, " model"}, {31'd0, expViol(a, wr)}, {31'd0, exp});
    request(a, wr, tag);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfgRdIdx = 3'(i);
      #1;
      check({tag, " R2 readback"}, cfgRdData, (i < 5) ? model[i] : 32'd0);
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    #1;
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 grant", {31'd0, rspGrant}, 32'd0);
    check("R1 violation", {31'd0, rspViolation}, 32'd0);
    check("R1 lock", {31'd0, lockState}, 32'd0);
    readAll("R1");

    // R2 field layout, reserved bits, bad index
    cfgWrite(0, 32'hFFFF_FFFF, 0, 0, '0, 0, "R2");
    cfgWrite(6, 32'h8001_0001, 0, 0, '0, 0, "R2 badidx");
    readAll("R2");
    cfgWrite(0, 32'd0, 0, 0, '0, 0, "R2 clear");

    // R3/R5: write guard on pages 0x010..0x012
    cfgWrite(1, mkReg(1, 0, 16, 18), 0, 0, '0, 0, "R3");
    expectReq(25'h010000, 1, 1, "R5 low edge");
    expectReq(25'h00FFFF, 1, 0, "R5 below");
    expectReq(25'h012FFF, 1, 1, "R5 high edge");
    expectReq(25'h013000, 1, 0, "R5 above");
    expectReq(25'h011800, 1, 1, "R3 mid");
    // R6: write-only window does not block reads
    expectReq(25'h011800, 0, 0, "R6 read through wr-guard");
    // R4/R6: read-only window
    cfgWrite(2, mkReg(0, 1, 32, 32), 0, 0, '0, 0, "R4");
    expectReq(25'h020ABC, 0, 1, "R4 read hit");
    expectReq(25'h020ABC, 1, 0, "R6 write through rd-guard");
    // R5: inverted window covers nothing
    cfgWrite(3, mkReg(1, 1, 50, 40), 0, 0, '0, 0, "R5 inv");
    expectReq(25'h02D000, 1, 0, "R5 inverted wr");
    expectReq(25'h028000, 0, 0, "R5 inverted rd");
    // R7 idle cycle
    @(negedge clk); @(posedge clk); #1;
    check("R7 idle", {29'd0, rspValid, rspGrant, rspViolation}, 32'd0);
    // R9: write and request collide; new window seen next cycle
    cfgWrite(4, mkReg(1, 1, 60, 60), 0, 1, 25'h03C123, 1, "R9");
    expectReq(25'h03C123, 1, 1, "R9 after write");

    // Random phase
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 4) == 0) begin
        int lo;
        int up;
        lo = $urandom % 48;
        up = (($urandom % 8) == 0) ? lo - 1 : lo + ($urandom % 12);
        cfgWrite($urandom % 6, mkReg(1'($urandom), 1'($urandom), lo, up),
                 0, 1'($urandom), 25'($urandom % (64 * 4096)), 1'($urandom), "R9 rnd");
      end else begin
        request(25'($urandom % (64 * 4096)), 1'($urandom), "R3 R4 rnd");
      end
    end
    readAll("R2 rnd");

    // R8: lock in same cycle as a write; later writes ignored
    cfgWrite(0, mkReg(1, 1, 0, 100), 1, 0, '0, 0, "R8 lockcycle");
    check("R8 lockState", {31'd0, lockState}, 32'd1);
    for (int n = 0; n < 10; n++)
      cfgWrite(n % 5, mkReg(1, 1, 0, 8191), 0, 0, '0, 0, "R8 locked");
    readAll("R8");
    for (int n = 0; n < 40; n++)
      request(25'($urandom % (64 * 4096)), 1'($urandom), "R8 locked rnd");
    check("R8 still locked", {31'd0, lockState}, 32'd1);

    // R8: reset lifts lock
    doReset();
    #1;
    check("R8 reset clears lock", {31'd0, lockState}, 32'd0);
    cfgWrite(1, mkReg(1, 0, 5, 5), 0, 0, '0, 0, "R8 after reset");
    readAll("R8 after reset");
    expectReq(25'h005000, 1, 1, "R8 after reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule